// File: doc/BRIEF.md
# Track Format Byte Translator

This block sits between the host's data register and the MFM encoder during a whole-track format write. A start pulse arms it: it raises its data-request flag at once so the host can preload the first byte, then waits for the rising edge of the index pulse. From that edge on, a byte-slot timer paces the output. Each slot takes one host byte and passes it to the encoder. Three reserved host codes are translated on the way. One writes an A1 sync mark and restarts the CRC. One writes a C2 pre-mark and leaves the CRC alone. One appends the running 16-bit CRC as two bytes.

A sync mark goes out with a missing-clock tag for the encoder. The run ends at the next rising edge of the index pulse. It also ends early if the host never supplies a first byte. The block flags a lost byte or a timeout for the status logic around it.

The controller has four states. IDLE moves to WAIT_INDEX on start. WAIT_INDEX moves to FORMAT on the index rising edge. FORMAT moves to CRC_LOW when a CRC code is consumed. CRC_LOW returns to FORMAT after the low CRC byte has been emitted. FORMAT and CRC_LOW go back to IDLE on the next index rising edge (the stop). FORMAT also goes back to IDLE on the timeout slot.

Top module: `trk_fmt_xlat`

## Requirements
- R1: A start pulse while idle raises busy and drq on the next clock; a start pulse while busy has no effect.
- R2: No byte is emitted before the first index rising edge after start. The first byte slot falls BYTE_CYCLES clocks after that edge. A byte loaded before the edge is held and is emitted in that first slot.
- R3: Host bytes 00..F4 and F8..FF are emitted unchanged with out_mclk = 0 and are folded into the CRC.
- R4: Host code F5 emits A1 with out_mclk = 1. The CRC is reseeded to FFFF, and that A1 is then folded in.
- R5: Host code F6 emits C2 with out_mclk = 1 and leaves the CRC unchanged.
- R6: Host code F7 emits the CRC high byte and, in the next slot, the low byte, both with out_mclk = 0. The CRC uses polynomial x^16+x^12+x^5+1 and is MSB first. The CRC bytes are not folded into the CRC.
- R7: A slot that finds the data register empty, once a first byte has been received, emits 00 (folded into the CRC) and sets lost_data. lost_data stays set until the next start.
- R8: If no host byte has been received by the third slot after the index edge, the run ends with timed_out set, a done pulse, busy low and no byte emitted.
- R9: The next index rising edge ends the run: done pulses for one clock, busy and drq drop, and no further byte is emitted.
- R10: drq is high exactly while busy and the data register is empty. A host write clears it, and a slot that consumes the byte raises it again.
- R11: Host writes while idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a format run (pulse) |
| index_in | input | 1 | Index pulse level from the drive |
| host_wr | input | 1 | Host write strobe for the data register |
| host_data | input | 8 | Host byte |
| drq | output | 1 | Data request: register empty while busy |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock pulse when a run ends |
| lost_data | output | 1 | A slot found no host byte |
| timed_out | output | 1 | Run ended for lack of a first byte |
| out_valid | output | 1 | One-clock strobe of an output byte |
| out_byte | output | 8 | Byte to the MFM encoder |
| out_mclk | output | 1 | Byte carries a missing-clock mark |

## Verification
The hardest case to reach is the CRC pair emitted after a mix of reseeding marks, unaltered pre-marks and plain bytes. In that case a wrong reseed or a wrong fold only shows up as a wrong pair of bytes many slots later. The stimulus walks a vector table that builds a sector header: three F5 marks, ID bytes and an F7 code. It follows this with an F6 pre-mark and more bytes before a second F7. The bench recomputes both CRC pairs with its own model. The timeout case needs writes made while idle to be dropped. It is reached by writing a byte before start and then withholding bytes after the index edge.

// File: rtl/tfx_pkg.sv
package tfx_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT_INDEX,
        S_FORMAT,
        S_CRC_LOW
    } tfx_state_e;

    typedef enum logic [1:0] {
        K_PLAIN,
        K_SYNC_A,
        K_SYNC_C,
        K_CRC
    } tfx_kind_e;

    localparam logic [7:0]  CODE_SYNC_A = 8'hF5;
    localparam logic [7:0]  CODE_SYNC_C = 8'hF6;
    localparam logic [7:0]  CODE_CRC    = 8'hF7;
    localparam logic [7:0]  MARK_A      = 8'hA1;
    localparam logic [7:0]  MARK_C      = 8'hC2;
    localparam logic [15:0] CRC_SEED    = 16'hFFFF;
    localparam logic [15:0] CRC_POLY    = 16'h1021;

    function automatic tfx_kind_e classify(input logic [7:0] b);
        tfx_kind_e k;
        unique case (b)
            CODE_SYNC_A: k = K_SYNC_A;
            CODE_SYNC_C: k = K_SYNC_C;
            CODE_CRC:    k = K_CRC;
            default:     k = K_PLAIN;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/tfx_crc16.sv
module tfx_crc16 #(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] SEED = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        reseed,
    input  logic        advance,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    function automatic logic [15:0] fold(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ d[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       crc <= SEED;
        else if (clear)   crc <= SEED;
        else if (reseed)  crc <= fold(SEED, din);
        else if (advance) crc <= fold(crc, din);
    end

endmodule

// File: rtl/tfx_slot_timer.sv
module tfx_slot_timer #(
    parameter int BYTE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);

    localparam int TW = (BYTE_CYCLES > 1) ? $clog2(BYTE_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(BYTE_CYCLES - 1);

    logic [TW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (run)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/tfx_host_reg.sv
module tfx_host_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       host_wr,
    input  logic [7:0] host_data,
    input  logic       take,
    output logic [7:0] data,
    output logic       full,
    output logic       drq
);

    assign drq = active && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (!active) begin
            full <= 1'b0;
        end else begin
            if (take) full <= 1'b0;
            if (host_wr) begin
                full <= 1'b1;
                data <= host_data;
            end
        end
    end

    // R10 / R11: the register only fills from a host write made while active
    a_r10_fill_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(host_wr && active));

    a_r11_idle_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !full);

endmodule

// File: rtl/trk_fmt_xlat.sv
module trk_fmt_xlat #(
    parameter int BYTE_CYCLES   = 16,
    parameter int TIMEOUT_SLOTS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       index_in,
    input  logic       host_wr,
    input  logic [7:0] host_data,
    output logic       drq,
    output logic       busy,
    output logic       done,
    output logic       lost_data,
    output logic       timed_out,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_mclk
);
    import tfx_pkg::*;

    localparam int MW = $clog2(TIMEOUT_SLOTS + 1);
    localparam logic [MW-1:0] MISS_LAST = MW'(TIMEOUT_SLOTS - 1);

    tfx_state_e state, state_nx;

    logic        idx_q, idx_rise;
    logic        tick, timer_restart, timer_run;
    logic [7:0]  reg_data;
    logic        reg_full, take;
    logic [15:0] crc;
    logic        crc_clear, crc_reseed, crc_adv;
    logic [7:0]  crc_din;
    logic        got_q, got;
    logic [MW-1:0] miss_cnt;
    logic        miss_inc;
    logic        emit, emit_mclk;
    logic [7:0]  emit_byte;
    logic        set_lost, set_timeout, fin;

    assign idx_rise  = index_in && !idx_q;
    assign busy      = (state != S_IDLE);
    assign timer_run = (state == S_FORMAT) || (state == S_CRC_LOW);
    assign got       = got_q || reg_full;

    tfx_slot_timer #(.BYTE_CYCLES(BYTE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(timer_restart),
        .run(timer_run), .tick(tick)
    );

    tfx_host_reg u_hreg (
        .clk(clk), .rst_n(rst_n), .active(busy), .host_wr(host_wr),
        .host_data(host_data), .take(take), .data(reg_data),
        .full(reg_full), .drq(drq)
    );

    tfx_crc16 #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
        .clk(clk), .rst_n(rst_n), .clear(crc_clear), .reseed(crc_reseed),
        .advance(crc_adv), .din(crc_din), .crc(crc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state and slot decisions
    always_comb begin
        state_nx      = state;
        timer_restart = 1'b0;
        take          = 1'b0;
        crc_clear     = 1'b0;
        crc_reseed    = 1'b0;
        crc_adv       = 1'b0;
        crc_din       = reg_data;
        miss_inc      = 1'b0;
        emit          = 1'b0;
        emit_mclk     = 1'b0;
        emit_byte     = 8'h00;
        set_lost      = 1'b0;
        set_timeout   = 1'b0;
        fin           = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    crc_clear = 1'b1;
                    state_nx  = S_WAIT_INDEX;
                end
            end
            S_WAIT_INDEX: begin
                if (idx_rise) begin
                    timer_restart = 1'b1;
                    state_nx      = S_FORMAT;
                end
            end
            S_FORMAT: begin
                if (idx_rise) begin
                    fin      = 1'b1;
                    state_nx = S_IDLE;
                end else if (tick) begin
                    if (reg_full) begin
                        take = 1'b1;
                        emit = 1'b1;
                        unique case (classify(reg_data))
                            K_PLAIN: begin
                                emit_byte = reg_data;
                                crc_adv   = 1'b1;
                            end
                            K_SYNC_A: begin
                                emit_byte  = MARK_A;
                                emit_mclk  = 1'b1;
                                crc_din    = MARK_A;
                                crc_reseed = 1'b1;
                            end
                            K_SYNC_C: begin
                                emit_byte = MARK_C;
                                emit_mclk = 1'b1;
                            end
                            K_CRC: begin
                                emit_byte = crc[15:8];
                                state_nx  = S_CRC_LOW;
                            end
                        endcase
                    end else if (got) begin
                        emit      = 1'b1;
                        emit_byte = 8'h00;
                        crc_din   = 8'h00;
                        crc_adv   = 1'b1;
                        set_lost  = 1'b1;
                    end else if (miss_cnt == MISS_LAST) begin
                        set_timeout = 1'b1;
                        fin         = 1'b1;
                        state_nx    = S_IDLE;
                    end else begin
                        miss_inc = 1'b1;
                    end
                end
            end
            S_CRC_LOW: begin
                if (idx_rise) begin
                    fin      = 1'b1;
                    state_nx = S_IDLE;
                end else if (tick) begin
                    emit      = 1'b1;
                    emit_byte = crc[7:0];
                    state_nx  = S_FORMAT;
                end
            end
        endcase
    end

    // registered outputs and run bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= 1'b0;
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_mclk  <= 1'b0;
            done      <= 1'b0;
            lost_data <= 1'b0;
            timed_out <= 1'b0;
            got_q     <= 1'b0;
            miss_cnt  <= '0;
        end else begin
            idx_q     <= index_in;
            out_valid <= emit;
            done      <= fin;
            if (emit) begin
                out_byte <= emit_byte;
                out_mclk <= emit_mclk;
            end
            if (crc_clear) begin
                lost_data <= 1'b0;
                timed_out <= 1'b0;
                got_q     <= 1'b0;
                miss_cnt  <= '0;
            end else begin
                if (set_lost)    lost_data <= 1'b1;
                if (set_timeout) timed_out <= 1'b1;
                if (reg_full)    got_q     <= 1'b1;
                if (miss_inc)    miss_cnt  <= miss_cnt + 1'b1;
            end
        end
    end

    a_r1_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |=> (busy && drq));

    a_r2_silent_before_index: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_INDEX) |-> !out_valid);

    a_r4_mark_values: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mclk) |-> (out_byte == MARK_A || out_byte == MARK_C));

    a_r6_low_byte_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CRC_LOW && tick && !idx_rise) |=> (out_valid && !out_mclk));

    a_r7_lost_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_data) |-> (out_valid && out_byte == 8'h00 && !out_mclk));

    a_r8_timeout_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timed_out) |-> (!busy && done && !out_valid));

    a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/sim_trk_fmt_xlat.sv
`timescale 1ns/1ps
module sim_trk_fmt_xlat;

    localparam int BC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       index_in = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       drq, busy, done, lost_data, timed_out, out_valid, out_mclk;
    logic [7:0] out_byte;

    always #10 clk = ~clk;

    trk_fmt_xlat #(.BYTE_CYCLES(BC), .TIMEOUT_SLOTS(3)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .index_in(index_in),
        .host_wr(host_wr), .host_data(host_data), .drq(drq), .busy(busy),
        .done(done), .lost_data(lost_data), .timed_out(timed_out),
        .out_valid(out_valid), .out_byte(out_byte), .out_mclk(out_mclk)
    );

    // {expected mclk, host byte, expected byte}; expected byte unused for F7
    localparam logic [16:0] VEC [18] = '{
        {1'b0, 8'h4E, 8'h4E}, {1'b0, 8'h4E, 8'h4E}, {1'b0, 8'h00, 8'h00},
        {1'b1, 8'hF5, 8'hA1}, {1'b1, 8'hF5, 8'hA1}, {1'b1, 8'hF5, 8'hA1},
        {1'b0, 8'hFE, 8'hFE}, {1'b0, 8'h05, 8'h05}, {1'b0, 8'h00, 8'h00},
        {1'b0, 8'h03, 8'h03}, {1'b0, 8'h02, 8'h02}, {1'b0, 8'hF7, 8'h00},
        {1'b0, 8'h4E, 8'h4E}, {1'b1, 8'hF6, 8'hC2}, {1'b0, 8'hF4, 8'hF4},
        {1'b0, 8'hF8, 8'hF8}, {1'b0, 8'hFF, 8'hFF}, {1'b0, 8'hF7, 8'h00}
    };

    int checks = 0;
    int fails  = 0;
    int n_out  = 0;
    int n_done = 0;
    logic [7:0] log_b [64];
    logic       log_m [64];
    logic [7:0] exp_b [64];
    logic       exp_m [64];
    string      exp_r [64];
    int         n_exp = 0;

    always @(negedge clk) begin
        if (out_valid) begin
            if (n_out < 64) begin
                log_b[n_out] = out_byte;
                log_m[n_out] = out_mclk;
            end
            n_out++;
        end
        if (done) n_done++;
    end

    function automatic logic [15:0] model_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int k = 0; k < 8; k++)
            r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic feed(input logic [7:0] b);
        while (!drq) @(negedge clk);
        host_wr   = 1'b1;
        host_data = b;
        @(negedge clk);
        host_wr   = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_index();
        index_in = 1'b1;
        repeat (3) @(negedge clk);
        index_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic push_exp(input logic [7:0] b, input logic m, input string r);
        exp_b[n_exp] = b;
        exp_m[n_exp] = m;
        exp_r[n_exp] = r;
        n_exp++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] mcrc;
        int base, done0, out0;
        logic [7:0] hb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(!busy && !drq && !out_valid && !lost_data && !timed_out && !done,
            "reset", {busy, drq, out_valid, lost_data, timed_out}, 0);

        // R11: write while idle, then start with no host writes -> timeout (R8)
        host_wr = 1'b1; host_data = 8'h55;
        @(negedge clk);
        host_wr = 1'b0;
        chk(!drq && !busy, "R11 idle write", {busy, drq}, 0);
        out0 = n_out; done0 = n_done;
        pulse_start();
        chk(busy && drq, "R1 start arms", {busy, drq}, 3);
        repeat (2 * BC) @(negedge clk);
        chk(n_out == out0, "R2 no output before index", n_out - out0, 0);
        pulse_index();
        repeat (3 * BC + 4) @(negedge clk);
        chk(timed_out && !busy, "R8 timeout", {timed_out, busy}, 2);
        chk(n_out == out0, "R8/R11 no byte emitted", n_out - out0, 0);
        chk(n_done == done0 + 1, "R8 done pulse", n_done - done0, 1);
        chk(!drq, "R10 drq low when idle", drq, 0);

        // vector walk: a header, a CRC pair, a pre-mark, a second CRC pair
        base = n_out;
        mcrc = 16'hFFFF;
        pulse_start();
        chk(!timed_out && !lost_data, "R1 flags cleared", {timed_out, lost_data}, 0);
        for (int i = 0; i < 18; i++) begin
            hb = VEC[i][15:8];
            feed(hb);
            if (i == 0) begin
                chk(!drq && busy, "R10 write clears drq", drq, 0);
                pulse_start();
                chk(busy, "R1 start while busy ignored", busy, 1);
                pulse_index();
            end
            if (hb == 8'hF7) begin
                push_exp(mcrc[15:8], 1'b0, "R6 crc high");
                push_exp(mcrc[7:0],  1'b0, "R6 crc low");
            end else if (hb == 8'hF5) begin
                push_exp(8'hA1, 1'b1, "R4 sync A1");
                mcrc = model_crc(16'hFFFF, 8'hA1);
            end else if (hb == 8'hF6) begin
                push_exp(8'hC2, 1'b1, "R5 pre-mark C2");
            end else begin
                push_exp(VEC[i][7:0], VEC[i][16], "R3 plain byte");
                mcrc = model_crc(mcrc, hb);
            end
        end
        chk(!lost_data, "R7 no loss while fed", lost_data, 0);
        chk(busy, "R9 still busy before index", busy, 1);

        // starve: zero bytes follow the last CRC pair (R7)
        repeat (6 * BC) @(negedge clk);
        for (int k = 0; k < n_exp; k++)
            chk(log_b[base + k] == exp_b[k] && log_m[base + k] == exp_m[k],
                exp_r[k], {log_m[base + k], log_b[base + k]}, {exp_m[k], exp_b[k]});
        chk(n_out > base + n_exp, "R7 filler emitted", n_out - base, n_exp + 1);
        chk(log_b[base + n_exp] == 8'h00 && !log_m[base + n_exp], "R7 filler is zero",
            log_b[base + n_exp], 0);
        chk(lost_data, "R7 lost flag", lost_data, 1);

        // stop at the next index edge (R9)
        done0 = n_done;
        index_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        out0 = n_out;
        chk(n_done == done0 + 1 && !busy && !drq, "R9 stop", {busy, drq}, 0);
        index_in = 1'b0;
        repeat (3 * BC) @(negedge clk);
        chk(n_out == out0, "R9 no bytes after stop", n_out - out0, 0);
        chk(n_done == done0 + 1, "R9 single done", n_done - done0, 1);
        pulse_index();
        chk(!busy, "R9 index while idle ignored", busy, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule